// File: doc/BRIEF.md
# Boot-Strapped Segment and Chip-Select Configuration

This block fixes the external memory arrangement of a chip at power-up. While system reset is held, it samples a three-bit segment-width strap and a second-ROM strap from board pins. It freezes both values when its internal reset ends. From the frozen segment code it works out how many upper segment address lines, starting at A16 and going no higher than A20, take over pins of a shared port. It drives one mode select per pin: address output or general-purpose I/O. Boot code can therefore reach the whole external space without programming anything first.

The frozen second-ROM strap decides whether the chip-select for the extra ROM can ever go active. Software sees both fields through a small register port. Reads return the frozen values. Writes are acknowledged like any other access but change nothing.

Top module: `memcfg_strap_top`

## Requirements
- R1: While the internal reset is active (rst_n low, and for the 2 clock edges after rst_n rises), every pin select is 0 (general-purpose I/O), seg_addr_o is 0, rom2_cs_n_o is 1 and sw_ack_o is 0.
- R2: The straps are sampled on every clock edge while the internal reset is active, including the edge that ends it. Strap changes after that edge have no effect on any output.
- R3: Bit i of pin_sel_o selects address line A(16+i). The segment code (MSB first) maps as follows: 111 gives 11111, 110 gives 01111, 101 gives 00111, 100 gives 00011 and 011 gives 00001. The codes 010, 001 and 000 give 00000.
- R4: With every strap pin high (no pull-downs), all five segment lines A20..A16 become address outputs.
- R5: seg_addr_o bit i equals seg_addr_i bit i when pin select i is 1, and is 0 otherwise.
- R6: When the second-ROM strap was low at lock, rom2_cs_n_o equals the inverse of rom2_sel_i. When it was high, rom2_cs_n_o stays 1 whatever rom2_sel_i does.
- R7: A read (sw_req_i=1, sw_we_i=0) returns on sw_rdata_o in the next cycle the frozen segment code in bits 5:3, with bit 5 as the MSB. Bit 1 is 1 when the second ROM is enabled. All other bits are 0.
- R8: A software write (sw_req_i=1, sw_we_i=1) changes neither sw_rdata_o, the pin selects nor the chip-select behaviour.
- R9: Every access made after lock is answered by sw_ack_o=1 in the next cycle.
- R10: A new reset samples the straps again, and the new values replace the old ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| strap_seg_i | input | 3 | Segment-width strap pins, MSB first |
| strap_rom2_n_i | input | 1 | Second-ROM strap, low enables the extra chip-select |
| seg_addr_i | input | 5 | Internal segment address bits A20..A16 (bit 0 = A16) |
| rom2_sel_i | input | 1 | Address decode hit for the second ROM |
| sw_req_i | input | 1 | Software access strobe |
| sw_we_i | input | 1 | Software access is a write |
| pin_sel_o | output | 5 | Per-pin mode, 1 = address output, bit 0 = A16 pin |
| seg_addr_o | output | 5 | Segment address to the pins, masked to enabled lines |
| rom2_cs_n_o | output | 1 | Active-low second-ROM chip-select |
| sw_ack_o | output | 1 | Access acknowledge |
| sw_rdata_o | output | 8 | Read data of the configuration register |

## Verification
Two things can coincide in one cycle: the last strap capture on the edge that ends internal reset, and a software write or a strap change. The bench issues a write while the release is still in progress. It also flips every strap pin on the cycle right after the locking edge. The result is judged by reading the register and by watching the pin selects and the chip-select: all of them must match the straps that were present at the locking edge.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
  // Number of segment lines above A15 that can be handed to the port.
  localparam int SEG_LINES    = 5;
  // Width of the segment strap code.
  localparam int CODE_W       = 3;
  // Configuration register width and field placement.
  localparam int CFG_W        = 8;
  localparam int SEG_FIELD_LO = 3;
  localparam int ROM2_BIT     = 1;
  // Reset release synchronizer depth.
  localparam int SYNC_STAGES  = 2;

  typedef enum logic {
    PIN_GPIO = 1'b0,
    PIN_ADDR = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/memcfg_rst_sync.sv
module memcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/memcfg_strap_latch.sv
module memcfg_strap_latch #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              capture_i,
  input  logic [CODE_W-1:0] seg_code_i,
  input  logic              rom2_n_i,
  output logic [CODE_W-1:0] seg_code_o,
  output logic              rom2_n_o
);
  // These flops have no reset on purpose. They follow the pins while the
  // internal reset is active and hold their values once it ends.
  logic [CODE_W-1:0] code_q, code_d;
  logic              rom2_q, rom2_d;

  always_comb begin
    code_d = code_q;
    rom2_d = rom2_q;
    if (capture_i) begin
      code_d = seg_code_i;
      rom2_d = rom2_n_i;
    end
  end

  always_ff @(posedge clk) begin
    code_q <= code_d;
    rom2_q <= rom2_d;
  end

  assign seg_code_o = code_q;
  assign rom2_n_o   = rom2_q;
endmodule

// File: rtl/memcfg_seg_decode.sv
module memcfg_seg_decode
  import memcfg_pkg::*;
#(
  parameter int CODE_W    = 3,
  parameter int SEG_LINES = 5
) (
  input  logic                 locked_i,
  input  logic [CODE_W-1:0]    seg_code_i,
  input  logic [SEG_LINES-1:0] seg_addr_i,
  output logic [SEG_LINES-1:0] pin_sel_o,
  output logic [SEG_LINES-1:0] seg_addr_o
);
  localparam int              CODE_MAX = (1 << CODE_W) - 1;
  localparam int              OFFSET   = CODE_MAX - SEG_LINES;
  localparam logic [CODE_W-1:0] OFF    = CODE_W'(OFFSET);

  logic [CODE_W-1:0] line_cnt;

  always_comb begin
    if (seg_code_i > OFF) line_cnt = seg_code_i - OFF;
    else                  line_cnt = '0;
  end

  for (genvar i = 0; i < SEG_LINES; i++) begin : g_pin
    localparam logic [CODE_W-1:0] IDX = CODE_W'(i);
    pin_mode_e mode;
    always_comb begin
      if (locked_i && (line_cnt > IDX)) mode = PIN_ADDR;
      else                              mode = PIN_GPIO;
    end
    assign pin_sel_o[i]  = (mode == PIN_ADDR);
    assign seg_addr_o[i] = seg_addr_i[i] & (mode == PIN_ADDR);
  end
endmodule

// File: rtl/memcfg_cfg_port.sv
module memcfg_cfg_port #(
  parameter int CODE_W  = 3,
  parameter int CFG_W   = 8,
  parameter int SEG_LO  = 3,
  parameter int ROM2_AT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked_i,
  input  logic [CODE_W-1:0] seg_code_i,
  input  logic              rom2_en_i,
  input  logic              sw_req_i,
  input  logic              sw_we_i,
  output logic              sw_ack_o,
  output logic [CFG_W-1:0]  sw_rdata_o
);
  logic [CFG_W-1:0] image;
  logic [CFG_W-1:0] rdata_q, rdata_d;
  logic             ack_q, ack_d;
  logic             rd_en;

  always_comb begin
    image                        = '0;
    image[SEG_LO +: CODE_W]      = seg_code_i;
    image[ROM2_AT]               = rom2_en_i;
  end

  // Writes are acknowledged but never load anything.
  assign rd_en = locked_i && sw_req_i && !sw_we_i;

  always_comb begin
    ack_d   = locked_i && sw_req_i;
    rdata_d = rdata_q;
    if (rd_en) rdata_d = image;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
    end
  end

  assign sw_ack_o   = ack_q;
  assign sw_rdata_o = rdata_q;
endmodule

// File: rtl/memcfg_strap_top.sv
module memcfg_strap_top
  import memcfg_pkg::*;
#(
  parameter int LINES  = SEG_LINES,
  parameter int CW     = CODE_W,
  parameter int RW     = CFG_W,
  parameter int SYNC_N = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] strap_seg_i,
  input  logic          strap_rom2_n_i,
  input  logic [LINES-1:0] seg_addr_i,
  input  logic          rom2_sel_i,
  input  logic          sw_req_i,
  input  logic          sw_we_i,
  output logic [LINES-1:0] pin_sel_o,
  output logic [LINES-1:0] seg_addr_o,
  output logic          rom2_cs_n_o,
  output logic          sw_ack_o,
  output logic [RW-1:0] sw_rdata_o
);
  logic          locked;
  logic [CW-1:0] seg_code;
  logic          rom2_n_q;
  logic          rom2_en;

  memcfg_rst_sync #(.STAGES(SYNC_N)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_sync_n_o (locked)
  );

  memcfg_strap_latch #(.CODE_W(CW)) u_latch (
    .clk        (clk),
    .capture_i  (!locked),
    .seg_code_i (strap_seg_i),
    .rom2_n_i   (strap_rom2_n_i),
    .seg_code_o (seg_code),
    .rom2_n_o   (rom2_n_q)
  );

  memcfg_seg_decode #(.CODE_W(CW), .SEG_LINES(LINES)) u_dec (
    .locked_i   (locked),
    .seg_code_i (seg_code),
    .seg_addr_i (seg_addr_i),
    .pin_sel_o  (pin_sel_o),
    .seg_addr_o (seg_addr_o)
  );

  assign rom2_en     = locked && !rom2_n_q;
  assign rom2_cs_n_o = !(rom2_en && rom2_sel_i);

  memcfg_cfg_port #(
    .CODE_W(CW), .CFG_W(RW), .SEG_LO(SEG_FIELD_LO), .ROM2_AT(ROM2_BIT)
  ) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .locked_i   (locked),
    .seg_code_i (seg_code),
    .rom2_en_i  (rom2_en),
    .sw_req_i   (sw_req_i),
    .sw_we_i    (sw_we_i),
    .sw_ack_o   (sw_ack_o),
    .sw_rdata_o (sw_rdata_o)
  );
endmodule

// File: rtl/memcfg_strap_chk.sv
module memcfg_strap_chk #(
  parameter int LINES = 5,
  parameter int RW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             locked,
  input logic             rom2_en,
  input logic             rom2_sel_i,
  input logic             sw_req_i,
  input logic             sw_we_i,
  input logic [LINES-1:0] pin_sel_o,
  input logic [LINES-1:0] seg_addr_o,
  input logic             rom2_cs_n_o,
  input logic             sw_ack_o,
  input logic [RW-1:0]    sw_rdata_o
);
  // R1: nothing leaves general-purpose mode before lock.
  a_r1_gpio_until_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (pin_sel_o == '0) && rom2_cs_n_o && (seg_addr_o == '0));

  // R3: enabled lines always form a contiguous run starting at A16.
  a_r3_contiguous_lines: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_sel_o + 1'b1) & pin_sel_o) == '0);

  // R5: no address bit escapes on a general-purpose pin.
  a_r5_no_leak: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_addr_o & ~pin_sel_o) == '0);

  // R6: a disabled second ROM never sees its select asserted.
  a_r6_rom2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom2_en || !rom2_sel_i) |-> rom2_cs_n_o);

  // R2: once locked, the configuration stays frozen.
  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> ($stable(pin_sel_o) && $stable(rom2_en)));

  // R8: a write leaves the read data untouched.
  a_r8_write_ignored: assert property (@(posedge clk) disable iff (!rst_n || !locked)
    (sw_req_i && sw_we_i) |=> $stable(sw_rdata_o));

  // R9: every access after lock is acknowledged next cycle.
  a_r9_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && sw_req_i) |=> sw_ack_o);
endmodule

bind memcfg_strap_top memcfg_strap_chk #(.LINES(LINES), .RW(RW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .locked      (locked),
  .rom2_en     (rom2_en),
  .rom2_sel_i  (rom2_sel_i),
  .sw_req_i    (sw_req_i),
  .sw_we_i     (sw_we_i),
  .pin_sel_o   (pin_sel_o),
  .seg_addr_o  (seg_addr_o),
  .rom2_cs_n_o (rom2_cs_n_o),
  .sw_ack_o    (sw_ack_o),
  .sw_rdata_o  (sw_rdata_o)
);

// File: tb/memcfg_strap_top_bench.sv
`timescale 1ns/1ps
module memcfg_strap_top_bench;
  logic       clk;
  logic       rst_n;
  logic [2:0] strap_seg;
  logic       strap_rom2_n;
  logic [4:0] seg_addr;
  logic       rom2_sel;
  logic       sw_req;
  logic       sw_we;
  logic [4:0] pin_sel;
  logic [4:0] seg_addr_out;
  logic       rom2_cs_n;
  logic       sw_ack;
  logic [7:0] sw_rdata;

  int n_checks = 0;
  int n_fails  = 0;

  memcfg_strap_top u_memcfg_strap_top (
    .clk(clk), .rst_n(rst_n), .strap_seg_i(strap_seg),
    .strap_rom2_n_i(strap_rom2_n), .seg_addr_i(seg_addr),
    .rom2_sel_i(rom2_sel), .sw_req_i(sw_req), .sw_we_i(sw_we),
    .pin_sel_o(pin_sel), .seg_addr_o(seg_addr_out),
    .rom2_cs_n_o(rom2_cs_n), .sw_ack_o(sw_ack), .sw_rdata_o(sw_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [4:0] exp_sel(input logic [2:0] code);
    int cnt;
    cnt = (code >= 3) ? int'(code) - 2 : 0;
    return 5'((1 << cnt) - 1);
  endfunction

  function automatic logic [7:0] exp_reg(input logic [2:0] code, input logic rom2_n);
    return {2'b00, code, 1'b0, ~rom2_n, 1'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  // Reset with given straps; optionally write during release; straps are
  // flipped right after the locking edge.
  task automatic do_reset(input logic [2:0] code, input logic rom2_n, input logic wr_in_release);
    @(negedge clk);
    rst_n = 1'b0; strap_seg = code; strap_rom2_n = rom2_n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sw_req = wr_in_release; sw_we = wr_in_release;
    @(negedge clk);
    // one edge seen after release: still locking
    sw_req = 1'b0; sw_we = 1'b0;
    @(negedge clk);
    // locking edge passed: flip straps, they must be ignored
    strap_seg = ~code; strap_rom2_n = ~rom2_n;
  endtask

  task automatic sw_read(output logic [7:0] data, output logic ack);
    @(negedge clk); sw_req = 1'b1; sw_we = 1'b0;
    @(negedge clk); sw_req = 1'b0; data = sw_rdata; ack = sw_ack;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 1'b0; strap_seg = 3'b111; strap_rom2_n = 1'b0;
    seg_addr = 5'h1F; rom2_sel = 1'b1; sw_req = 1'b1; sw_we = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 pin_sel in reset", 32'(pin_sel), 0);
    check("R1 seg_addr in reset", 32'(seg_addr_out), 0);
    check("R1 cs_n in reset", 32'(rom2_cs_n), 1);
    check("R1 ack in reset", 32'(sw_ack), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pin_sel during release", 32'(pin_sel), 0);
    check("R1 cs_n during release", 32'(rom2_cs_n), 1);
    sw_req = 1'b0;
    @(negedge clk);
    check("R4 default all lines", 32'(pin_sel), 32'h1F);
  endtask

  task automatic t_decode_all;
    logic [7:0] d; logic a;
    for (int c = 0; c < 8; c++) begin
      do_reset(3'(c), 1'b1, 1'b0);
      @(negedge clk);
      check("R3 decode", 32'(pin_sel), 32'(exp_sel(3'(c))));
      check("R2 flipped straps ignored", 32'(pin_sel), 32'(exp_sel(3'(c))));
      sw_read(d, a);
      check("R7 readback", 32'(d), 32'(exp_reg(3'(c), 1'b1)));
      check("R9 read ack", 32'(a), 1);
    end
  endtask

  task automatic t_mask;
    do_reset(3'b101, 1'b1, 1'b0);
    seg_addr = 5'h1F; #1;
    check("R5 mask all ones", 32'(seg_addr_out), 32'h07);
    seg_addr = 5'h1A; #1;
    check("R5 mask pattern", 32'(seg_addr_out), 32'h02);
    seg_addr = 5'h05; #1;
    check("R5 mask low bits", 32'(seg_addr_out), 32'h05);
  endtask

  task automatic t_rom2;
    logic [7:0] d; logic a;
    do_reset(3'b110, 1'b0, 1'b0);
    rom2_sel = 1'b1; #1;
    check("R6 enabled select", 32'(rom2_cs_n), 0);
    rom2_sel = 1'b0; #1;
    check("R6 enabled idle", 32'(rom2_cs_n), 1);
    sw_read(d, a);
    check("R7 rom2 bit set", 32'(d), 32'(exp_reg(3'b110, 1'b0)));
    do_reset(3'b110, 1'b1, 1'b0);
    rom2_sel = 1'b1; #1;
    check("R6 disabled held high", 32'(rom2_cs_n), 1);
    check("R10 re-sampled rom2", 32'(rom2_cs_n), 1);
  endtask

  task automatic t_write_ignored;
    logic [7:0] d; logic a;
    do_reset(3'b100, 1'b0, 1'b0);
    sw_read(d, a);
    @(negedge clk); sw_req = 1'b1; sw_we = 1'b1;
    @(negedge clk); sw_req = 1'b0; sw_we = 1'b0;
    check("R9 write ack", 32'(sw_ack), 1);
    check("R8 rdata after write", 32'(sw_rdata), 32'(exp_reg(3'b100, 1'b0)));
    check("R8 pins after write", 32'(pin_sel), 32'h03);
    rom2_sel = 1'b1; #1;
    check("R8 cs after write", 32'(rom2_cs_n), 0);
    rom2_sel = 1'b0;
  endtask

  task automatic t_collision;
    logic [7:0] d; logic a;
    do_reset(3'b011, 1'b0, 1'b1);
    @(negedge clk);
    check("R2 pins after write at release", 32'(pin_sel), 32'h01);
    sw_read(d, a);
    check("R2 reg after write at release", 32'(d), 32'(exp_reg(3'b011, 1'b0)));
    do_reset(3'b111, 1'b1, 1'b0);
    sw_read(d, a);
    check("R10 new straps replace old", 32'(d), 32'(exp_reg(3'b111, 1'b1)));
  endtask

  initial begin
    rst_n = 1'b0; strap_seg = 3'b111; strap_rom2_n = 1'b1;
    seg_addr = '0; rom2_sel = 1'b0; sw_req = 1'b0; sw_we = 1'b0;
    t_reset_state();
    t_decode_all();
    t_mask();
    t_rom2();
    t_write_ignored();
    t_collision();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule